// File: doc/BRIEF.md
# Width-Selectable Adder/Subtractor with Condition Flags

This block is the arithmetic core of a small 32-bit processor's execute stage. It is purely combinational. It takes two 32-bit register operands, an operation code and a per-instruction width selector. It returns the sum or difference computed at 8, 16 or 32 bits, together with a three-bit condition code.

All of the condition bits are taken from the selected lane and not from the whole word. An 8-bit operation therefore reports its own carry or borrow, its own sign and its own zero state. Operand bits above the chosen width take no part in the result. The result is zero-filled above the chosen width. The surrounding pipeline decides when the result and flags are committed.

Top module: `alu_width_flags`

## Requirements
- R1: With op code 0 (ADD), the low W bits of `result_o` equal (a + b) mod 2^W. W is 8, 16 or 32 for width codes 0, 1 and 2.
- R2: With op code 1 (SUB), the low W bits of `result_o` equal (a - b) mod 2^W.
- R3: For width codes 0 and 1, the bits of `result_o` above the selected width are zero.
- R4: For ADD, the carry flag is the carry out of bit W-1 of the unsigned W-bit addition.
- R5: For SUB, the carry flag is the borrow: it is set exactly when the low W bits of a, read as unsigned, are below the low W bits of b.
- R6: The negative flag equals bit W-1 of the result.
- R7: The zero flag is set exactly when the low W bits of the result are all zero.
- R8: `flags_o` is packed as {carry, negative, zero}, from bit 2 down to bit 0. An 8-bit SUB of 8'hFF minus 8'h01 gives 8'hFE and `flags_o` 3'b010.
- R9: Width code 3 behaves exactly like width code 2 (32-bit).
- R10: Operand bits above the selected width have no effect on `result_o` or `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand (minuend for SUB) |
| b_i | input | 32 | Second operand (subtrahend for SUB) |
| op_i | input | 1 | Operation: 0 ADD, 1 SUB |
| width_i | input | 2 | Width: 0 8-bit, 1 16-bit, 2 or 3 32-bit |
| result_o | output | 32 | Result, zero-filled above the selected width |
| flags_o | output | 3 | {carry, negative, zero} at the selected width |

## Verification
The interesting collisions happen when a single operation raises several flags at once. A carry or borrow and a zero result can appear together, as in 8'hFF + 8'h01. A borrow and a negative result can also appear together. The bench forces these cases with directed operands at every width, and it also feeds random operands whose upper bits are polluted. Each output is compared, field by field, against a model that works in 64-bit integers with an explicit width mask.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } alu_op_e;

  typedef enum logic [1:0] {
    WID_8   = 2'd0,
    WID_16  = 2'd1,
    WID_32  = 2'd2,
    WID_32X = 2'd3
  } alu_width_e;

  typedef struct packed {
    logic c;
    logic n;
    logic z;
  } alu_flags_t;

  // Lane index: the code for 32 bits and the spare code share lane 2.
  function automatic logic [1:0] lane_index(input logic [1:0] wcode);
    return (wcode == WID_32X) ? 2'd2 : wcode;
  endfunction

  // Carry bit to report: a raw carry for ADD, an inverted carry (a borrow) for SUB.
  function automatic logic report_carry(input logic sub, input logic raw_cout);
    return sub ? ~raw_cout : raw_cout;
  endfunction
endpackage

// File: rtl/alu_lane.sv
module alu_lane #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic              msb_o,
  output logic              zero_o
);
  logic [LANE_W-1:0] b_eff;
  logic [LANE_W:0]   sum;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign sum    = {1'b0, a_i} + {1'b0, b_eff} + {{LANE_W{1'b0}}, sub_i};
  assign res_o  = DATA_W'(sum[LANE_W-1:0]);
  assign cout_o = sum[LANE_W];
  assign msb_o  = sum[LANE_W-1];
  assign zero_o = (sum[LANE_W-1:0] == '0);
endmodule

// File: rtl/alu_lane_sel.sv
module alu_lane_sel #(
  parameter int DATA_W    = 32,
  parameter int NUM_LANES = 3
) (
  input  logic [NUM_LANES-1:0][DATA_W-1:0] res_i,
  input  logic [NUM_LANES-1:0]             cout_i,
  input  logic [NUM_LANES-1:0]             msb_i,
  input  logic [NUM_LANES-1:0]             zero_i,
  input  logic [1:0]                       idx_i,
  output logic [DATA_W-1:0]                res_o,
  output logic                             cout_o,
  output logic                             msb_o,
  output logic                             zero_o
);
  always_comb begin
    res_o  = res_i[NUM_LANES-1];
    cout_o = cout_i[NUM_LANES-1];
    msb_o  = msb_i[NUM_LANES-1];
    zero_o = zero_i[NUM_LANES-1];
    for (int k = 0; k < NUM_LANES; k++) begin
      if (idx_i == 2'(k)) begin
        res_o  = res_i[k];
        cout_o = cout_i[k];
        msb_o  = msb_i[k];
        zero_o = zero_i[k];
      end
    end
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_pkg::*;
(
  input  logic       sub_i,
  input  logic       cout_i,
  input  logic       msb_i,
  input  logic       zero_i,
  output alu_flags_t flags_o
);
  always_comb begin
    flags_o.c = report_carry(sub_i, cout_i);
    flags_o.n = msb_i;
    flags_o.z = zero_i;
  end
endmodule

// File: rtl/alu_width_flags.sv
module alu_width_flags
  import alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              op_i,
  input  logic [1:0]        width_i,
  output logic [DATA_W-1:0] result_o,
  output logic [2:0]        flags_o
);
  localparam int NUM_LANES = 3;

  function automatic int lane_w(input int g);
    return (g == 0) ? NARROW_W : (g == 1) ? MID_W : DATA_W;
  endfunction

  logic [NUM_LANES-1:0][DATA_W-1:0] lane_res;
  logic [NUM_LANES-1:0]             lane_cout;
  logic [NUM_LANES-1:0]             lane_msb;
  logic [NUM_LANES-1:0]             lane_zero;

  // Named internal events, also visible to the bound checker
  logic [1:0]  sel_idx;
  logic        sel_cout;
  logic        sel_msb;
  logic        sel_zero;
  alu_flags_t  flags_s;

  assign sel_idx = lane_index(width_i);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    alu_lane #(.DATA_W(DATA_W), .LANE_W(lane_w(g))) u_lane (
      .a_i   (a_i[lane_w(g)-1:0]),
      .b_i   (b_i[lane_w(g)-1:0]),
      .sub_i (op_i),
      .res_o (lane_res[g]),
      .cout_o(lane_cout[g]),
      .msb_o (lane_msb[g]),
      .zero_o(lane_zero[g])
    );
  end

  alu_lane_sel #(.DATA_W(DATA_W), .NUM_LANES(NUM_LANES)) u_sel (
    .res_i (lane_res),
    .cout_i(lane_cout),
    .msb_i (lane_msb),
    .zero_i(lane_zero),
    .idx_i (sel_idx),
    .res_o (result_o),
    .cout_o(sel_cout),
    .msb_o (sel_msb),
    .zero_o(sel_zero)
  );

  alu_flag_gen u_flags (
    .sub_i  (op_i),
    .cout_i (sel_cout),
    .msb_i  (sel_msb),
    .zero_i (sel_zero),
    .flags_o(flags_s)
  );

  assign flags_o = flags_s;
endmodule

// File: rtl/alu_width_flags_chk.sv
module alu_width_flags_chk #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              op_i,
  input logic [1:0]        width_i,
  input logic [DATA_W-1:0] result_o,
  input logic [2:0]        flags_o,
  input logic [1:0]        sel_idx
);
  logic [DATA_W-1:0] msk;
  logic [DATA_W-1:0] top_bit;
  logic [DATA_W-1:0] am, bm;
  logic [DATA_W:0]   wide_sum;
  logic              exp_cy;

  always_comb begin
    case (width_i)
      2'd0:    msk = DATA_W'((64'd1 << NARROW_W) - 64'd1);
      2'd1:    msk = DATA_W'((64'd1 << MID_W) - 64'd1);
      default: msk = '1;
    endcase
    top_bit  = msk ^ (msk >> 1);
    am       = a_i & msk;
    bm       = b_i & msk;
    wide_sum = {1'b0, am} + {1'b0, bm};
    exp_cy   = ((wide_sum[DATA_W-1:0] & ~msk) != '0) || wide_sum[DATA_W];
    if (!$isunknown({a_i, b_i, op_i, width_i})) begin
      assert_zero_fill_R3: assert ((result_o & ~msk) == '0)
        else $error("upper result bits not zero");
      assert_neg_flag_R6: assert (flags_o[1] == ((result_o & top_bit) != '0))
        else $error("negative flag mismatch");
      assert_zero_flag_R7: assert (flags_o[0] == ((result_o & msk) == '0))
        else $error("zero flag mismatch");
      if (!op_i) begin
        assert_add_carry_R4: assert (flags_o[2] == exp_cy)
          else $error("add carry mismatch");
      end else begin
        assert_sub_borrow_R5: assert (flags_o[2] == (am < bm))
          else $error("sub borrow mismatch");
      end
      assert_spare_width_R9: assert ((width_i != 2'd3) || (sel_idx == 2'd2))
        else $error("spare width code not on 32-bit lane");
    end
  end
endmodule

bind alu_width_flags alu_width_flags_chk #(
  .DATA_W(DATA_W), .NARROW_W(NARROW_W), .MID_W(MID_W)
) u_chk (.*);

// File: tb/tb_alu_width_flags.sv
module tb_alu_width_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] a, b;
  logic        op;
  logic [1:0]  wd;
  logic [31:0] res;
  logic [2:0]  flg;
  int total = 0;
  int bad = 0;
  bit done = 0;

  alu_width_flags dut (
    .a_i(a), .b_i(b), .op_i(op), .width_i(wd),
    .result_o(res), .flags_o(flg)
  );

  function automatic longint unsigned wmask(input logic [1:0] w);
    return (w == 2'd0) ? 64'hFF : (w == 2'd1) ? 64'hFFFF : 64'hFFFF_FFFF;
  endfunction

  function automatic int wbits(input logic [1:0] w);
    return (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [34:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic o, input logic [1:0] w);
    longint unsigned m, xm, ym, s, r;
    logic c, n, z;
    m  = wmask(w);
    xm = x & m;
    ym = y & m;
    if (!o) begin
      s = xm + ym;
      c = ((s >> wbits(w)) & 64'd1) != 0;
    end else begin
      s = xm - ym;
      c = xm < ym;
    end
    r = s & m;
    n = ((r >> (wbits(w) - 1)) & 64'd1) != 0;
    z = (r == 0);
    return {c, n, z, r[31:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [31:0] y,
                       input logic o, input logic [1:0] w);
    @(negedge clk);
    a = x; b = y; op = o; wd = w;
    #1;
  endtask

  task automatic full(input logic [31:0] x, input logic [31:0] y,
                      input logic o, input logic [1:0] w, input string tag);
    logic [34:0] e;
    apply(x, y, o, w);
    e = model(x, y, o, w);
    chk({tag, " result"}, res, e[31:0]);
    chk({tag, " flags"}, {29'd0, flg}, {29'd0, e[34:32]});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0;
    logic [2:0]  f0;
    int unsigned seed;
    a = '0; b = '0; op = 1'b0; wd = 2'd0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    chk("R7 idle zero result", res, 32'd0);
    chk("R7 idle flags", {29'd0, flg}, 32'd1);

    // R8: 8-bit FF - 01 = FE, flags 010
    apply(32'h0000_00FF, 32'h0000_0001, 1'b1, 2'd0);
    chk("R8 fe result", res, 32'h0000_00FE);
    chk("R8 fe flags", {29'd0, flg}, 32'd2);
    // R4 + R7: carry and zero together at each width
    full(32'h0000_00FF, 32'h0000_0001, 1'b0, 2'd0, "R4 c+z 8");
    chk("R4 c+z 8 flags", {29'd0, flg}, 32'd5);
    full(32'h0000_FFFF, 32'h0000_0001, 1'b0, 2'd1, "R4 c+z 16");
    full(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 2'd2, "R4 c+z 32");
    // R5 + R6: borrow with negative
    full(32'h0000_0003, 32'h0000_0005, 1'b1, 2'd0, "R5 borrow 8");
    chk("R5 borrow 8 flags", {29'd0, flg}, 32'd6);
    full(32'h0000_0000, 32'h0000_0001, 1'b1, 2'd1, "R5 borrow 16");
    full(32'h1234_5678, 32'h1234_5678, 1'b1, 2'd2, "R7 equal 32");
    full(32'h0000_7FFF, 32'h0000_0001, 1'b0, 2'd1, "R6 sign 16");
    full(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 2'd2, "R1 overflow 32");
    full(32'h8000_0000, 32'h0000_0001, 1'b1, 2'd2, "R2 sub 32");
    // R3: upper bits zero despite full operands
    full(32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0, 2'd0, "R3 fill 8");
    chk("R3 fill 8 upper", res & 32'hFFFF_FF00, 32'd0);
    full(32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b1, 2'd1, "R3 fill 16");
    chk("R3 fill 16 upper", res & 32'hFFFF_0000, 32'd0);

    // R9: width 3 matches width 2
    for (int i = 0; i < 20; i++) begin
      logic [31:0] x, y;
      logic o;
      x = $urandom; y = $urandom; o = 1'($urandom);
      apply(x, y, o, 2'd2);
      r0 = res; f0 = flg;
      apply(x, y, o, 2'd3);
      chk("R9 spare width result", res, r0);
      chk("R9 spare width flags", {29'd0, flg}, {29'd0, f0});
    end

    // R10: upper operand bits do not matter
    seed = 32'd77;
    void'($urandom(seed));
    for (int i = 0; i < 40; i++) begin
      logic [31:0] x, y;
      logic o;
      logic [1:0] w;
      x = $urandom; y = $urandom; o = 1'($urandom); w = 2'($urandom % 2);
      apply(x & 32'(wmask(w)), y & 32'(wmask(w)), o, w);
      r0 = res; f0 = flg;
      apply(x, y, o, w);
      chk("R10 upper ignored result", res, r0);
      chk("R10 upper ignored flags", {29'd0, flg}, {29'd0, f0});
    end

    // Random mix, R1 and R2 across widths
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      logic o;
      logic [1:0] w;
      x = $urandom; y = $urandom; o = 1'($urandom); w = 2'($urandom % 3);
      if (i % 8 == 0) y = x;
      full(x, y, o, w, o ? "R2 random" : "R1 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule